// File: doc/BRIEF.md
# Region-Scoped Reader-Writer Lock Table

This block keeps a small table of reader-writer lock records, one per tracked location, shared by a fixed group of hardware threads. A thread that wants to touch a location presents its thread id, the location index, the access kind and its current stage number. One cycle later the table answers with one of four results. The result is hit when the thread already holds the lock strongly enough. It is acquired when the lock was taken or joined. It is upgraded when a sole reader became the writer. It is blocked when another thread stands in the way, and then the blocking holders are listed. Locks are not dropped after each access. A thread keeps them until its region ends. At that point it pulses its end-of-region input and the table sweeps every record to drop that thread's holds.

Two options refine the policy. With lazy retention enabled, each record carries the stage number of its latest holder. A requester whose stage is strictly newer may take the lock away from stale holders. A request can also be flagged as mutex-only, so a read takes the lock exclusively just like a write. A single-location release lets a thread give up one lock before its region ends.

Top module: `lockTable`

## Requirements
- R1: After reset every record is free, `busy` is low and `rspValid` is low; the first access to any location is answered acquired (code 01).
- R2: A read (op 00) of a free lock takes it shared and a write (op 01) takes it exclusive, both answered acquired (01). A read by another thread joins a shared lock with acquired (01). Any access by another thread to an exclusive lock is blocked (11), with the owner's bit set in `rspBlockers`.
- R3: A thread repeating an access that its current hold already covers (a read or write under exclusive, a read under shared) is answered hit (00) and the holders do not change.
- R4: A write by the only reader of a shared lock is answered upgraded (10), and the lock is exclusive afterwards.
- R5: A write to a shared lock that has readers other than the requester is blocked (11), and `rspBlockers` equals exactly those other readers. Non-blocked results always show `rspBlockers` as zero.
- R6: A release request (op 10) drops only the requester's hold on that one location and produces no response. The lock becomes free when no holder is left.
- R7: A pulse on `endRegion[t]` raises `busy` for DEPTH+1 cycles while the table is swept. Requests presented while `busy` is high are ignored and get no response. Afterwards thread t holds no lock.
- R8: With `lazyEn` high, a conflicting request whose stage is strictly greater than the record's stage steals the lock. The requester becomes the only holder in the mode it needs, and the result is acquired (01). An equal or smaller stage, or `lazyEn` low, gives blocked.
- R9: Every hit, acquire, upgrade or steal writes the requester's stage into the record's stage field.
- R10: With `reqMutex` high a read needs the lock exclusively, so it takes a free lock exclusive and is blocked by another thread's shared hold.
- R11: A response appears exactly one cycle after the accepted request, and one request can be accepted every cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| reqValid | input | 1 | Request present this cycle |
| reqThread | input | 2 | Requesting thread id |
| reqAddr | input | 4 | Lock record index |
| reqOp | input | 2 | 00 read, 01 write, 10 release one location, 11 ignored |
| reqStage | input | 4 | Requester's current stage number |
| reqMutex | input | 1 | Treat a read as needing exclusive ownership |
| lazyEn | input | 1 | Allow stage-based stealing |
| endRegion | input | 4 | One pulse per thread: drop all that thread's locks |
| busy | output | 1 | Sweep pending or running; requests ignored |
| rspValid | output | 1 | Response valid |
| rspCode | output | 2 | 00 hit, 01 acquired, 10 upgraded, 11 blocked |
| rspBlockers | output | 4 | Bit per thread that blocks the request |

## Verification
The assertions assume that stage numbers do not wrap within the life of a lock, because stage ordering is an unsigned compare. They also assume that `reqThread` names a real thread. The stimulus draws stages from the 4-bit range without relying on wrap. It keeps the thread id within the four threads. It raises end-of-region pulses only when no request is driven in the same cycle, so the sweep never races with a write to the same record. Random traffic is kept to four locations so that conflicts, upgrades and steals happen often.

// File: rtl/lockTablePkg.sv
package lockTablePkg;
  localparam int unsigned NUM_THR = 4;
  localparam int unsigned ADDR_W  = 4;
  localparam int unsigned STAGE_W = 4;
  localparam int unsigned TID_W   = $clog2(NUM_THR);
  localparam int unsigned DEPTH   = 1 << ADDR_W;

  typedef enum logic [1:0] {MODE_FREE = 2'b00, MODE_SHARED = 2'b01, MODE_EXCL = 2'b10} modeT;
  typedef enum logic [1:0] {OP_READ = 2'b00, OP_WRITE = 2'b01, OP_RELEASE = 2'b10} opT;
  typedef enum logic [1:0] {RSP_HIT = 2'b00, RSP_ACQ = 2'b01, RSP_UPG = 2'b10, RSP_BLK = 2'b11} rspT;

  typedef struct packed {
    logic               wrEn;
    logic [ADDR_W-1:0]  wrAddr;
    logic [NUM_THR-1:0] wrHold;
    modeT               wrMode;
    logic [STAGE_W-1:0] wrStage;
    logic               clrEn;
    logic [ADDR_W-1:0]  clrAddr;
    logic [NUM_THR-1:0] clrMask;
  } strobeT;
endpackage

// File: rtl/lockTableDp.sv
module lockTableDp
  import lockTablePkg::*;
(
  input  logic               clk,
  input  logic               rstN,
  input  strobeT             stb,
  input  logic [ADDR_W-1:0]  rdAddr,
  output logic [NUM_THR-1:0] rdHold,
  output modeT               rdMode,
  output logic [STAGE_W-1:0] rdStage
);
  logic [NUM_THR-1:0] holdQ  [DEPTH];
  modeT               modeQ  [DEPTH];
  logic [STAGE_W-1:0] stageQ [DEPTH];

  always_ff @(posedge clk) begin
    if (!rstN) begin
      for (int i = 0; i < DEPTH; i++) begin
        holdQ[i]  <= '0;
        modeQ[i]  <= MODE_FREE;
        stageQ[i] <= '0;
      end
    end else begin
      if (stb.wrEn) begin
        holdQ[stb.wrAddr]  <= stb.wrHold;
        modeQ[stb.wrAddr]  <= stb.wrMode;
        stageQ[stb.wrAddr] <= stb.wrStage;
      end
      if (stb.clrEn) begin
        holdQ[stb.clrAddr] <= holdQ[stb.clrAddr] & ~stb.clrMask;
        if ((holdQ[stb.clrAddr] & ~stb.clrMask) == '0)
          modeQ[stb.clrAddr] <= MODE_FREE;
      end
    end
  end

  assign rdHold  = holdQ[rdAddr];
  assign rdMode  = modeQ[rdAddr];
  assign rdStage = stageQ[rdAddr];

  for (genvar g = 0; g < DEPTH; g++) begin : gChk
    AST_EXCL_ONE_OWNER: assert property (@(posedge clk) disable iff (!rstN)
      modeQ[g] == MODE_EXCL |-> $countones(holdQ[g]) == 1); // R2
    AST_FREE_IFF_EMPTY: assert property (@(posedge clk) disable iff (!rstN)
      (modeQ[g] == MODE_FREE) == (holdQ[g] == '0)); // R1
    AST_SWEEP_CLEARS: assert property (@(posedge clk) disable iff (!rstN)
      stb.clrEn && stb.clrAddr == ADDR_W'(g) |=> (holdQ[g] & $past(stb.clrMask)) == '0); // R7
  end
endmodule

// File: rtl/lockTableCtl.sv
module lockTableCtl
  import lockTablePkg::*;
(
  input  logic               clk,
  input  logic               rstN,
  input  logic               reqValid,
  input  logic [TID_W-1:0]   reqThread,
  input  logic [ADDR_W-1:0]  reqAddr,
  input  logic [1:0]         reqOp,
  input  logic [STAGE_W-1:0] reqStage,
  input  logic               reqMutex,
  input  logic               lazyEn,
  input  logic [NUM_THR-1:0] endRegion,
  input  logic [NUM_THR-1:0] rdHold,
  input  modeT               rdMode,
  input  logic [STAGE_W-1:0] rdStage,
  output strobeT             stb,
  output logic               busy,
  output logic               rspValid,
  output logic [1:0]         rspCode,
  output logic [NUM_THR-1:0] rspBlockers
);
  logic [NUM_THR-1:0] pendQ, actQ;
  logic [ADDR_W-1:0]  idxQ;
  logic [TID_W-1:0]   rspThrQ;
  logic               sweepStart, sweepLast;

  logic [NUM_THR-1:0] tBit, others, nxHold, nxBlk;
  logic               mine, needExcl, canSteal, accept, doWr, doRsp;
  modeT               nxMode, needMode;
  logic [STAGE_W-1:0] nxStage;
  rspT                nxCode;

  assign busy       = (pendQ != '0) || (actQ != '0);
  assign sweepStart = (actQ == '0) && (pendQ != '0);
  assign sweepLast  = (actQ != '0) && (idxQ == ADDR_W'(DEPTH - 1));

  always_comb begin
    tBit     = NUM_THR'(1) << reqThread;
    mine     = (rdHold & tBit) != '0;
    others   = rdHold & ~tBit;
    needExcl = (reqOp == OP_WRITE) || reqMutex;
    needMode = needExcl ? MODE_EXCL : MODE_SHARED;
    canSteal = lazyEn && (reqStage > rdStage);
    accept   = reqValid && !busy;
    nxHold   = rdHold;
    nxMode   = rdMode;
    nxStage  = rdStage;
    nxCode   = RSP_HIT;
    nxBlk    = '0;
    doWr     = 1'b0;
    doRsp    = 1'b0;
    if (accept && reqOp == OP_RELEASE) begin
      doWr   = 1'b1;
      nxHold = rdHold & ~tBit;
      if (nxHold == '0) nxMode = MODE_FREE;
    end else if (accept && (reqOp == OP_READ || reqOp == OP_WRITE)) begin
      doRsp   = 1'b1;
      doWr    = 1'b1;
      nxStage = reqStage;
      if (rdMode == MODE_FREE) begin
        nxCode = RSP_ACQ;
        nxHold = tBit;
        nxMode = needMode;
      end else if (mine && (rdMode == MODE_EXCL || !needExcl)) begin
        nxCode = RSP_HIT;
      end else if (mine && others == '0) begin
        nxCode = RSP_UPG;
        nxMode = MODE_EXCL;
      end else if (!mine && rdMode == MODE_SHARED && !needExcl) begin
        nxCode = RSP_ACQ;
        nxHold = rdHold | tBit;
      end else if (canSteal) begin
        nxCode = RSP_ACQ;
        nxHold = tBit;
        nxMode = needMode;
      end else begin
        nxCode  = RSP_BLK;
        nxBlk   = others;
        doWr    = 1'b0;
        nxStage = rdStage;
      end
    end
    stb.wrEn    = doWr;
    stb.wrAddr  = reqAddr;
    stb.wrHold  = nxHold;
    stb.wrMode  = nxMode;
    stb.wrStage = nxStage;
    stb.clrEn   = actQ != '0;
    stb.clrAddr = idxQ;
    stb.clrMask = actQ;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      pendQ       <= '0;
      actQ        <= '0;
      idxQ        <= '0;
      rspValid    <= 1'b0;
      rspCode     <= RSP_HIT;
      rspBlockers <= '0;
      rspThrQ     <= '0;
    end else begin
      pendQ <= sweepStart ? endRegion : (pendQ | endRegion);
      if (sweepStart) begin
        actQ <= pendQ;
        idxQ <= '0;
      end else if (actQ != '0) begin
        idxQ <= idxQ + 1'b1;
        if (sweepLast) actQ <= '0;
      end
      rspValid    <= doRsp;
      rspCode     <= nxCode;
      rspBlockers <= nxBlk;
      rspThrQ     <= reqThread;
    end
  end

  AST_BLOCK_NAMES_OTHERS: assert property (@(posedge clk) disable iff (!rstN)
    rspValid && rspCode == RSP_BLK |-> rspBlockers != '0 && rspBlockers[rspThrQ] == 1'b0); // R5
  AST_CLEAN_BLOCKERS: assert property (@(posedge clk) disable iff (!rstN)
    rspValid && rspCode != RSP_BLK |-> rspBlockers == '0); // R5
  AST_BUSY_SILENT: assert property (@(posedge clk) disable iff (!rstN)
    busy && reqValid |=> !rspValid); // R7
  AST_ONE_CYCLE_RSP: assert property (@(posedge clk) disable iff (!rstN)
    !busy && reqValid && (reqOp == OP_READ || reqOp == OP_WRITE) |=> rspValid); // R11
endmodule

// File: rtl/lockTable.sv
module lockTable
  import lockTablePkg::*;
(
  input  logic               clk,
  input  logic               rstN,
  input  logic               reqValid,
  input  logic [TID_W-1:0]   reqThread,
  input  logic [ADDR_W-1:0]  reqAddr,
  input  logic [1:0]         reqOp,
  input  logic [STAGE_W-1:0] reqStage,
  input  logic               reqMutex,
  input  logic               lazyEn,
  input  logic [NUM_THR-1:0] endRegion,
  output logic               busy,
  output logic               rspValid,
  output logic [1:0]         rspCode,
  output logic [NUM_THR-1:0] rspBlockers
);
  strobeT             stb;
  logic [NUM_THR-1:0] rdHold;
  modeT               rdMode;
  logic [STAGE_W-1:0] rdStage;

  lockTableCtl u_ctl (
    .clk(clk), .rstN(rstN), .reqValid(reqValid), .reqThread(reqThread),
    .reqAddr(reqAddr), .reqOp(reqOp), .reqStage(reqStage), .reqMutex(reqMutex),
    .lazyEn(lazyEn), .endRegion(endRegion), .rdHold(rdHold), .rdMode(rdMode),
    .rdStage(rdStage), .stb(stb), .busy(busy), .rspValid(rspValid),
    .rspCode(rspCode), .rspBlockers(rspBlockers)
  );

  lockTableDp u_dp (
    .clk(clk), .rstN(rstN), .stb(stb), .rdAddr(reqAddr),
    .rdHold(rdHold), .rdMode(rdMode), .rdStage(rdStage)
  );
endmodule

// File: tb/lockTable_bench.sv
module lockTable_bench;
  localparam int CLK_PERIOD = 10;
  localparam int NT = 4;
  localparam int ND = 16;

  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic       reqValid = 1'b0;
  logic [1:0] reqThread = '0;
  logic [3:0] reqAddr = '0;
  logic [1:0] reqOp = '0;
  logic [3:0] reqStage = '0;
  logic       reqMutex = 1'b0;
  logic       lazyEn = 1'b0;
  logic [3:0] endRegion = '0;
  logic       busy, rspValid;
  logic [1:0] rspCode;
  logic [3:0] rspBlockers;

  int checks = 0;
  int errors = 0;
  bit finished = 0;

  logic [3:0] mHold [ND];
  int         mMode [ND];
  int         mStage [ND];

  always #(CLK_PERIOD/2) clk = ~clk;

  lockTable u_lockTable (
    .clk(clk), .rstN(rstN), .reqValid(reqValid), .reqThread(reqThread),
    .reqAddr(reqAddr), .reqOp(reqOp), .reqStage(reqStage), .reqMutex(reqMutex),
    .lazyEn(lazyEn), .endRegion(endRegion), .busy(busy), .rspValid(rspValid),
    .rspCode(rspCode), .rspBlockers(rspBlockers)
  );

  task automatic check(input bit ok, input string req, input string what, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  // expected result of an access, from the requirements
  task automatic access(input int t, input int a, input int op, input int st, input bit mx, input string req);
    logic [3:0] tb, hold, others, nh, eb;
    int nm, ns, ec;
    bit mine, need;
    tb = 4'(1 << t);
    hold = mHold[a];
    mine = hold[t];
    others = hold & ~tb;
    need = (op == 1) || mx;
    nh = hold; nm = mMode[a]; ns = mStage[a]; ec = 0; eb = '0;
    if (op == 2) begin
      nh = hold & ~tb;
      if (nh == 0) nm = 0;
    end else begin
      ns = st;
      if (mMode[a] == 0) begin ec = 1; nh = tb; nm = need ? 2 : 1; end
      else if (mine && (mMode[a] == 2 || !need)) ec = 0;
      else if (mine && others == 0) begin ec = 2; nm = 2; end
      else if (!mine && mMode[a] == 1 && !need) begin ec = 1; nh = hold | tb; end
      else if (lazyEn && st > mStage[a]) begin ec = 1; nh = tb; nm = need ? 2 : 1; end
      else begin ec = 3; eb = others; ns = mStage[a]; end
    end
    reqValid = 1'b1; reqThread = 2'(t); reqAddr = 4'(a); reqOp = 2'(op);
    reqStage = 4'(st); reqMutex = mx;
    @(negedge clk);
    reqValid = 1'b0;
    if (op == 2) begin
      check(!rspValid, req, "release gives no response", int'(rspValid), 0);
    end else begin
      check(rspValid, req, "rspValid", int'(rspValid), 1);
      check(int'(rspCode) == ec, req, "rspCode", int'(rspCode), ec);
      check(rspBlockers == eb, req, "rspBlockers", int'(rspBlockers), int'(eb));
    end
    mHold[a] = nh; mMode[a] = nm; mStage[a] = ns;
  endtask

  task automatic endReg(input int t, input string req);
    int cnt = 0;
    endRegion = 4'(1 << t);
    @(negedge clk);
    endRegion = '0;
    while (busy && cnt < 1000) begin
      if (cnt == 1) begin
        reqValid = 1'b1; reqThread = 2'((t + 1) % NT); reqAddr = '0;
        reqOp = 2'd1; reqStage = 4'd15; reqMutex = 1'b0;
      end
      @(negedge clk);
      if (cnt == 1) begin
        reqValid = 1'b0;
        check(!rspValid, req, "request during sweep answered", int'(rspValid), 0);
      end
      cnt++;
    end
    check(cnt == ND + 1, req, "busy cycles", cnt, ND + 1);
    for (int i = 0; i < ND; i++) begin
      mHold[i][t] = 1'b0;
      if (mHold[i] == 0) mMode[i] = 0;
    end
  endtask

  initial begin
    for (int i = 0; i < ND; i++) begin mHold[i] = '0; mMode[i] = 0; mStage[i] = 0; end
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    check(!busy, "R1", "busy after reset", int'(busy), 0);
    check(!rspValid, "R1", "rspValid after reset", int'(rspValid), 0);
    access(0, 9, 0, 0, 0, "R1");
    access(0, 9, 2, 0, 0, "R6");
    // R2 shared join and exclusive conflict
    access(0, 1, 0, 0, 0, "R2");
    access(1, 1, 0, 0, 0, "R2");
    access(2, 2, 1, 0, 0, "R2");
    access(3, 2, 0, 0, 0, "R2");
    // R3 covered repeats
    access(2, 2, 0, 1, 0, "R3");
    access(2, 2, 1, 1, 0, "R3");
    access(0, 1, 0, 0, 0, "R3");
    // R5 write with other reader
    access(0, 1, 1, 0, 0, "R5");
    // R6 single release, then R4 upgrade
    access(1, 1, 2, 0, 0, "R6");
    access(0, 1, 1, 0, 0, "R4");
    access(1, 1, 0, 0, 0, "R4");
    // R8 stealing
    lazyEn = 1'b1;
    access(3, 1, 1, 0, 0, "R8");
    lazyEn = 1'b0;
    access(3, 1, 1, 5, 0, "R8");
    lazyEn = 1'b1;
    access(3, 1, 1, 5, 0, "R8");
    access(0, 1, 0, 3, 0, "R8");
    // R9 hit refreshes stage
    access(3, 1, 0, 9, 0, "R9");
    access(0, 1, 1, 7, 0, "R9");
    access(0, 1, 1, 10, 0, "R9");
    lazyEn = 1'b0;
    // R10 mutex reads
    access(1, 3, 0, 0, 1, "R10");
    access(2, 3, 0, 0, 0, "R10");
    access(1, 4, 0, 0, 0, "R10");
    access(2, 4, 0, 0, 1, "R10");
    // R7 region end
    endReg(1, "R7");
    access(2, 3, 0, 0, 0, "R7");
    access(2, 4, 1, 0, 0, "R7");
    // R11 back-to-back random traffic
    void'($urandom(32'h5eed1));
    for (int n = 0; n < 3000; n++) begin
      int r = $urandom % 100;
      if (r < 2) endReg($urandom % NT, "R7");
      else if (r < 4) lazyEn = ~lazyEn;
      else access($urandom % NT, $urandom % 4, ($urandom % 5 == 0) ? 2 : $urandom % 2,
                  $urandom % 16, ($urandom % 8 == 0), "R11");
    end
    finished = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      checks++;
      errors++;
      $display("FAIL watchdog: actual=timeout expected=done");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end
endmodule